// File: doc/BRIEF.md
# Row-Router Broadcast Address Network

This block distributes cache request addresses across a grid of banks. It does not put a router at every bank. Each row of banks has a single row router, and a point-to-point link joins the cache controller to that router. The network decodes the row field of an incoming request and steers the request into that row's private pipeline. The pipeline has three parts: link stages, router stages and bus stages. The last part is the row bus. Its only master is the row router, so no arbitration takes place and the bus is pipelined as deep as its latency requires. At the end of the bus, every bank in the row sees the same address. Each bank compares the column field with its own position, so only the addressed bank raises its request-valid output.

Requests for different rows travel in separate pipelines, so several rows can work at the same time. Each row accepts at most one new request per cycle. A bank row that cannot take a broadcast raises its hold input. The held request then stays at the end of the bus, and the requests behind it close up into the empty stages. When all stages of a row are occupied, the network lowers its ready output for requests that target that row. Requests for the other rows are still accepted.

Top module: `row_bcast_net`

## Requirements
- R1: After reset no bank-valid output is high, and `reqReady` is high.
- R2: The column is taken from address bits [COL_W-1:0] and the row from bits [COL_W+ROW_W-1:COL_W] (bits [1:0] and [3:2] at the defaults). A request raises only the valid bit at index row*COLS+col, and at most one bank per row is valid in any cycle.
- R3: With no hold, a request accepted in cycle n (`reqValid` and `reqReady` both high at the rising edge that ends cycle n) raises its bank-valid bit during cycle n+6. This is LINK_CYC+RTR_STG+BUS_STG cycles at the defaults of 1, 3 and 2.
- R4: While a bank-valid bit of row r is high, the row-r slice of `bankAddr` carries the full 24-bit request address.
- R5: A row takes one request per cycle. Back-to-back requests to one row come out on consecutive cycles in acceptance order, and none is lost.
- R6: While `rowHold[r]` is high, no bank in row r is valid. The held request and the requests queued behind it stay in order and come out after the hold drops.
- R7: When all six stages of a row are occupied and the row is held, `reqReady` is low for a request that targets that row. It returns high once the hold drops.
- R8: A stalled row does not block other rows. A request for another row is still accepted and arrives with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Controller offers a request |
| reqAddr | input | ADDR_W (24) | Request address, carrying the row and column fields |
| reqReady | output | 1 | The target row can take the offered request this cycle |
| rowHold | input | ROWS (4) | Per row: the banks of this row cannot take a broadcast now |
| bankValid | output | ROWS*COLS (16) | One request-valid bit per bank, at index row*COLS+col |
| bankAddr | output | ROWS*ADDR_W (96) | Per-row bus address, with row r in bits [r*24 +: 24] |

## Verification
The hardest state to reach is a completely full row. It needs the last stage held while six requests pack into the stages behind it, and it has to coexist with a second row that keeps flowing at full speed. The stimulus raises the hold on row 0 before any request reaches the end of that row's pipeline. It then feeds six row-0 requests back to back, which fill the row. The bench then offers a seventh row-0 request and confirms for several cycles that it is refused. While row 0 is still stalled, the bench sends row-1 requests and checks that they arrive on the exact cycle. Finally it releases the hold and checks that the six queued row-0 requests come out in order.

// File: rtl/rbn_pkg.sv
package rbn_pkg;
  localparam int unsigned DEF_ROWS     = 4;
  localparam int unsigned DEF_COLS     = 4;
  localparam int unsigned DEF_ADDR_W   = 24;
  localparam int unsigned DEF_LINK_CYC = 1;
  localparam int unsigned DEF_RTR_STG  = 3;
  localparam int unsigned DEF_BUS_STG  = 2;
  localparam int unsigned DEF_DEPTH    = DEF_LINK_CYC + DEF_RTR_STG + DEF_BUS_STG;

  // width of an index field that selects one of n items (at least one bit)
  function automatic int unsigned fieldW(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // control-to-datapath strobes for the default geometry
  typedef struct packed {
    logic [DEF_ROWS-1:0][DEF_DEPTH-1:0] shift;
    logic [DEF_ROWS-1:0]                fire;
  } strobe_t;
endpackage

// File: rtl/rbn_ctrl.sv
module rbn_ctrl #(
  parameter int unsigned ROWS  = rbn_pkg::DEF_ROWS,
  parameter int unsigned DEPTH = rbn_pkg::DEF_DEPTH,
  parameter type strobe_t = rbn_pkg::strobe_t
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic [ROWS-1:0] reqRowOh,
  input  logic [ROWS-1:0] rowHold,
  output logic            reqReady,
  output strobe_t         strobe
);
  logic [ROWS-1:0][DEPTH-1:0] stageVld;
  logic [ROWS-1:0][DEPTH-1:0] moveOut;
  logic [ROWS-1:0][DEPTH-1:0] stageFree;
  logic [ROWS-1:0][DEPTH-1:0] loadStg;
  logic [ROWS-1:0]            firstFree;

  // Walk each row from the bus end back to the link end.
  // A stage's content moves on when the stage ahead of it is free.
  always_comb begin
    logic down;
    moveOut   = '0;
    stageFree = '0;
    for (int r = 0; r < ROWS; r++) begin
      down = ~rowHold[r];
      for (int i = DEPTH - 1; i >= 0; i--) begin
        moveOut[r][i]   = stageVld[r][i] & down;
        stageFree[r][i] = ~stageVld[r][i] | down;
        down            = ~stageVld[r][i] | down;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign firstFree[r]  = stageFree[r][0];
    assign loadStg[r][0] = reqValid & reqRowOh[r] & stageFree[r][0];
    for (genvar i = 1; i < DEPTH; i++) begin : g_stg
      assign loadStg[r][i] = stageVld[r][i-1] & stageFree[r][i];
    end
    assign strobe.fire[r] = moveOut[r][DEPTH-1];

    // R6: a held request at the bus end stays put
    p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stageVld[r][DEPTH-1] && rowHold[r]) |=> stageVld[r][DEPTH-1]);

    // R7: a full, held row never takes a new request
    p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((&stageVld[r]) && rowHold[r] && reqRowOh[r]) |-> !reqReady);
  end

  assign strobe.shift = loadStg;
  assign reqReady     = |(reqRowOh & firstFree);

  always_ff @(posedge clk) begin
    if (!rst_n) stageVld <= '0;
    else        stageVld <= (stageVld & ~moveOut) | loadStg;
  end

  // R2: one accepted request enters at most one row
  p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqRowOh));
endmodule

// File: rtl/rbn_dpath.sv
module rbn_dpath #(
  parameter int unsigned ROWS   = rbn_pkg::DEF_ROWS,
  parameter int unsigned COLS   = rbn_pkg::DEF_COLS,
  parameter int unsigned ADDR_W = rbn_pkg::DEF_ADDR_W,
  parameter int unsigned DEPTH  = rbn_pkg::DEF_DEPTH,
  parameter int unsigned ROW_W  = rbn_pkg::fieldW(ROWS),
  parameter int unsigned COL_W  = rbn_pkg::fieldW(COLS),
  parameter type strobe_t = rbn_pkg::strobe_t
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  strobe_t                strobe,
  output logic [ROWS-1:0]        reqRowOh,
  output logic [ROWS*COLS-1:0]   bankValid,
  output logic [ROWS*ADDR_W-1:0] bankAddr
);
  logic [ADDR_W-1:0] pipeAddr [ROWS][DEPTH];
  logic [ROW_W-1:0]  rowIdx;

  assign rowIdx = reqAddr[COL_W +: ROW_W];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign reqRowOh[r] = (rowIdx == ROW_W'(r));

    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      always_ff @(posedge clk) begin
        if (!rst_n)                pipeAddr[r][i] <= '0;
        else if (strobe.shift[r][i]) begin
          if (i == 0) pipeAddr[r][i] <= reqAddr;
          else        pipeAddr[r][i] <= pipeAddr[r][(i == 0) ? 0 : i-1];
        end
      end
    end

    assign bankAddr[r*ADDR_W +: ADDR_W] = pipeAddr[r][DEPTH-1];

    // per-bank position match on the row bus
    for (genvar c = 0; c < COLS; c++) begin : g_bank
      assign bankValid[r*COLS + c] = strobe.fire[r] &&
        (pipeAddr[r][DEPTH-1][COL_W-1:0] == COL_W'(c));
    end

    // R2: at most one bank of a row answers a broadcast
    p_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bankValid[r*COLS +: COLS]));

    // R2: the control only loads a row whose field matched
    p_row_steer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.shift[r][0] |-> reqRowOh[r]);
  end
endmodule

// File: rtl/row_bcast_net.sv
module row_bcast_net #(
  parameter int unsigned ROWS     = rbn_pkg::DEF_ROWS,
  parameter int unsigned COLS     = rbn_pkg::DEF_COLS,
  parameter int unsigned ADDR_W   = rbn_pkg::DEF_ADDR_W,
  parameter int unsigned LINK_CYC = rbn_pkg::DEF_LINK_CYC,
  parameter int unsigned RTR_STG  = rbn_pkg::DEF_RTR_STG,
  parameter int unsigned BUS_STG  = rbn_pkg::DEF_BUS_STG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   reqReady,
  input  logic [ROWS-1:0]        rowHold,
  output logic [ROWS*COLS-1:0]   bankValid,
  output logic [ROWS*ADDR_W-1:0] bankAddr
);
  localparam int unsigned DEPTH = LINK_CYC + RTR_STG + BUS_STG;
  localparam int unsigned ROW_W = rbn_pkg::fieldW(ROWS);
  localparam int unsigned COL_W = rbn_pkg::fieldW(COLS);

  typedef struct packed {
    logic [ROWS-1:0][DEPTH-1:0] shift;
    logic [ROWS-1:0]            fire;
  } netStrobe_t;

  netStrobe_t      strobe;
  logic [ROWS-1:0] reqRowOh;

  rbn_ctrl #(.ROWS(ROWS), .DEPTH(DEPTH), .strobe_t(netStrobe_t)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqRowOh(reqRowOh),
    .rowHold(rowHold), .reqReady(reqReady), .strobe(strobe));

  rbn_dpath #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
              .ROW_W(ROW_W), .COL_W(COL_W), .strobe_t(netStrobe_t)) u_dpath (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr), .strobe(strobe),
    .reqRowOh(reqRowOh), .bankValid(bankValid), .bankAddr(bankAddr));

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    // R6: a held row shows no valid bank
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rowHold[r] |-> (bankValid[r*COLS +: COLS] == '0));
  end
endmodule

// File: tb/row_bcast_net_tb.sv
`timescale 1ns/100ps
module row_bcast_net_tb;
  localparam int D = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqValid;
  logic [23:0] reqAddr;
  logic        reqReady;
  logic [3:0]  rowHold;
  logic [15:0] bankValid;
  logic [95:0] bankAddr;

  always #2.5 clk = ~clk;

  row_bcast_net u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rowHold(rowHold), .bankValid(bankValid),
    .bankAddr(bankAddr));

  typedef struct {
    logic [23:0] addr;
    int          due;
    bit          exact;
    string       tag;
  } exp_t;

  exp_t q [4][$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // driver: offer a request at a falling edge and wait for it to be taken
  task automatic send(input logic [23:0] a, input bit exact, input string tag);
    exp_t e;
    reqAddr  = a;
    reqValid = 1'b1;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    e.addr  = a;
    e.due   = cyc + D;
    e.exact = exact;
    e.tag   = tag;
    q[a[3:2]].push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: scoreboard compare for every row
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        for (int r = 0; r < 4; r++) begin
          logic [3:0] bits;
          exp_t e;
          bits = bankValid[r*4 +: 4];
          if (rowHold[r]) chk(bits == 4'd0, "R6", "held row shows valid", bits, 0);
          if (bits != 4'd0) begin
            if (q[r].size() == 0) begin
              chk(1'b0, "R2", "unexpected bank valid", bits, 0);
            end else begin
              e = q[r].pop_front();
              chk(bits == 4'(1 << e.addr[1:0]), e.tag, "bank select", bits, 4'(1 << e.addr[1:0]));
              chk(bankAddr[r*24 +: 24] == e.addr, e.tag, "bus address", bankAddr[r*24 +: 24], e.addr);
              if (e.exact) chk(cyc == e.due, e.tag, "arrival cycle", cyc, e.due);
              else         chk(cyc >= e.due, e.tag, "arrival not early", cyc, e.due);
            end
          end else if (q[r].size() > 0 && q[r][0].exact && cyc > q[r][0].due) begin
            chk(1'b0, "R3", "missing arrival", cyc, q[r][0].due);
            void'(q[r].pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    reqValid = 1'b0;
    reqAddr  = '0;
    rowHold  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(bankValid == 16'd0, "R1", "bank valid after reset", bankValid, 0);
    chk(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    @(negedge clk);

    // R2 R3 R4: every bank once, rows interleaved, varied upper bits
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        send({20'(32'h5A3C0 + r * 7 + c * 131), 2'(r), 2'(c)}, 1'b1, "R2/R3/R4");
      end
    end
    repeat (10) @(negedge clk);

    // R5: back-to-back stream to one row
    for (int k = 0; k < 5; k++) begin
      send({20'(32'hC0DE0 + k), 2'd2, 2'(3 - (k % 4))}, 1'b1, "R5");
    end
    repeat (10) @(negedge clk);

    // R6 R7: fill row 0 behind a hold
    rowHold[0] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      send({20'(32'h31000 + k), 2'd0, 2'(k % 4)}, 1'b0, "R6");
    end
    reqAddr  = {20'h77777, 2'd0, 2'd1};
    reqValid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(reqReady == 1'b0, "R7", "ready for full held row", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;

    // R8: another row still flows while row 0 is stalled
    send({20'h8A001, 2'd1, 2'd2}, 1'b1, "R8");
    send({20'h8A002, 2'd1, 2'd0}, 1'b1, "R8");
    repeat (10) @(negedge clk);

    rowHold[0] = 1'b0;
    reqAddr    = {20'h77777, 2'd0, 2'd1};
    #1;
    chk(reqReady == 1'b1, "R7", "ready after hold release", reqReady, 1);
    repeat (15) @(negedge clk);

    for (int r = 0; r < 4; r++) begin
      chk(q[r].size() == 0, "R5", "requests not delivered", q[r].size(), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule